// File: doc/BRIEF.md
# Interrupt status, mask and clear unit

This unit gathers the event indications of a two-wire bus controller into one 32-bit raw status word. Six positions mirror the live fill state of the transmit and receive FIFOs; nine positions record one-cycle event pulses from the bus engine and hold them until software clears them. A mask register selects which raw positions may reach the masked status word, and one interrupt line is raised whenever any masked position is set.

Software writes the mask register through a write strobe with a data word, and clears held events by writing ones through a separate clear strobe. Raw status, masked status and the mask are always visible on output ports for readback. The FIFOs and the bus engine that produce the inputs sit outside this unit.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Raw bits 0 (TX empty), 1 (TX nearly empty), 2 (TX full), 4 (RX empty), 5 (RX nearly full) and 6 (RX full) equal their level inputs in the same cycle and are never held.
- R2: A pulse on TX overrun, slave read request, slave read empty, slave write request, master done, slave done, arbitration lost, bus error or master done without stop sets raw bit 3, 16, 17, 18, 19, 20, 24, 25 or 28 respectively from the next cycle on, and the bit stays set until cleared.
- R3: A clear strobe clears, from the next cycle, each held bit whose position is one in the data word; only positions inside 0x131f007f are clearable, other data bits have no effect, and clearing a level position does not change it.
- R4: When a pulse and a clear of the same bit occur in one cycle, the bit is set afterwards.
- R5: A mask write stores the data word from the next cycle; bits 31 to 29 of the mask and of raw status always read zero, as do all raw positions without an event.
- R6: Masked status equals raw status ANDed with the mask.
- R7: The interrupt output is high exactly when masked status is nonzero; an all-zero mask holds it low.
- R8: Reset (active-low, synchronous) clears the mask and every held event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_empty_i | input | 1 | Transmit FIFO empty level |
| tx_low_i | input | 1 | Transmit FIFO nearly empty level |
| tx_full_i | input | 1 | Transmit FIFO full level |
| rx_empty_i | input | 1 | Receive FIFO empty level |
| rx_high_i | input | 1 | Receive FIFO nearly full level |
| rx_full_i | input | 1 | Receive FIFO full level |
| tx_ovr_i | input | 1 | Transmit overrun pulse |
| sl_rd_req_i | input | 1 | Slave read request pulse |
| sl_rd_empty_i | input | 1 | Slave read with empty FIFO pulse |
| sl_wr_req_i | input | 1 | Slave write request pulse |
| mst_done_i | input | 1 | Master transaction done (with stop) pulse |
| slv_done_i | input | 1 | Slave transaction done pulse |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| bus_err_i | input | 1 | Bus error pulse |
| mst_done_ns_i | input | 1 | Master transaction done without stop pulse |
| mask_wr_i | input | 1 | Mask register write strobe |
| clr_wr_i | input | 1 | Clear register write strobe |
| wdata_i | input | 32 | Write data for mask or clear |
| mask_o | output | 32 | Mask register readback |
| raw_stat_o | output | 32 | Raw status |
| mask_stat_o | output | 32 | Masked status |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench targets a pulse and a clear of the same bit in one cycle, where a design giving the clear priority would lose the event and drop the interrupt. It writes clear words filled with reserved and unused positions, which a design without the clearable filter would pass on harmlessly only by luck, and a clear to live FIFO positions, which a design holding those bits would wrongly drop or keep. It writes all ones to the mask to catch a top field that fails to read zero, and it resets with events and mask loaded to catch state that survives reset.

// File: rtl/evt_irq_pkg.sv
// Shared constants for the interrupt status unit: bit positions of every
// event and the derived position maps. Assumes a 32-bit status word.
package evt_irq_pkg;
    localparam int STAT_W = 32;

    // level-type FIFO positions
    localparam int P_TX_EMPTY  = 0;
    localparam int P_TX_LOW    = 1;
    localparam int P_TX_FULL   = 2;
    localparam int P_RX_EMPTY  = 4;
    localparam int P_RX_HIGH   = 5;
    localparam int P_RX_FULL   = 6;

    // held event positions
    localparam int P_TX_OVR     = 3;
    localparam int P_SL_RD_REQ  = 16;
    localparam int P_SL_RD_EMP  = 17;
    localparam int P_SL_WR_REQ  = 18;
    localparam int P_MST_DONE   = 19;
    localparam int P_SLV_DONE   = 20;
    localparam int P_ARB_LOST   = 24;
    localparam int P_BUS_ERR    = 25;
    localparam int P_MST_DONENS = 28;

    // positions a clear write may touch
    localparam logic [STAT_W-1:0] CLEARABLE_MAP = 32'h131f_007f;
    // positions that follow live FIFO levels
    localparam logic [STAT_W-1:0] LEVEL_MAP = 32'h0000_0077;
    // positions that latch until cleared
    localparam logic [STAT_W-1:0] HELD_MAP = CLEARABLE_MAP & ~LEVEL_MAP;
endpackage

// File: rtl/evt_map.sv
// Places the named level and pulse inputs at their fixed positions in two
// status-wide vectors. Purely combinational; assumes WORD_W >= 29.
module evt_map #(
    parameter int WORD_W = 32
) (
    input  logic              tx_empty_i,
    input  logic              tx_low_i,
    input  logic              tx_full_i,
    input  logic              rx_empty_i,
    input  logic              rx_high_i,
    input  logic              rx_full_i,
    input  logic              tx_ovr_i,
    input  logic              sl_rd_req_i,
    input  logic              sl_rd_empty_i,
    input  logic              sl_wr_req_i,
    input  logic              mst_done_i,
    input  logic              slv_done_i,
    input  logic              arb_lost_i,
    input  logic              bus_err_i,
    input  logic              mst_done_ns_i,
    output logic [WORD_W-1:0] lvl_vec_o,
    output logic [WORD_W-1:0] set_vec_o
);
    import evt_irq_pkg::*;

    // Build the live level vector.
    always_comb begin
        lvl_vec_o             = '0;
        lvl_vec_o[P_TX_EMPTY] = tx_empty_i;
        lvl_vec_o[P_TX_LOW]   = tx_low_i;
        lvl_vec_o[P_TX_FULL]  = tx_full_i;
        lvl_vec_o[P_RX_EMPTY] = rx_empty_i;
        lvl_vec_o[P_RX_HIGH]  = rx_high_i;
        lvl_vec_o[P_RX_FULL]  = rx_full_i;
    end

    // Build the event set vector.
    always_comb begin
        set_vec_o               = '0;
        set_vec_o[P_TX_OVR]     = tx_ovr_i;
        set_vec_o[P_SL_RD_REQ]  = sl_rd_req_i;
        set_vec_o[P_SL_RD_EMP]  = sl_rd_empty_i;
        set_vec_o[P_SL_WR_REQ]  = sl_wr_req_i;
        set_vec_o[P_MST_DONE]   = mst_done_i;
        set_vec_o[P_SLV_DONE]   = slv_done_i;
        set_vec_o[P_ARB_LOST]   = arb_lost_i;
        set_vec_o[P_BUS_ERR]    = bus_err_i;
        set_vec_o[P_MST_DONENS] = mst_done_ns_i;
    end
endmodule

// File: rtl/evt_held_bank.sv
// Register bank of held event bits. A set pulse has priority over a clear
// in the same cycle. Only HELD positions exist; clears are filtered by
// CLR_MAP so reserved positions of the clear word have no effect.
module evt_held_bank #(
    parameter int                WORD_W   = 32,
    parameter logic [WORD_W-1:0] HELD     = '0,
    parameter logic [WORD_W-1:0] CLR_MAP  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_i,
    input  logic              clr_stb_i,
    input  logic [WORD_W-1:0] clr_data_i,
    output logic [WORD_W-1:0] held_o
);
    logic [WORD_W-1:0] clr_eff;

    // Qualify the clear word by strobe and clearable positions.
    always_comb clr_eff = clr_stb_i ? (clr_data_i & CLR_MAP) : '0;

    // Latch events, drop cleared bits, event wins on collision.
    always_ff @(posedge clk) begin
        if (!rst_n) held_o <= '0;
        else        held_o <= HELD & (set_i | (held_o & ~clr_eff));
    end
endmodule

// File: rtl/evt_mask_reg.sv
// Interrupt mask register. The top RSVD_TOP bits are never stored and
// read zero. Loads on the write strobe; reset clears it.
module evt_mask_reg #(
    parameter int WORD_W   = 32,
    parameter int RSVD_TOP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] mask_o
);
    localparam int KEEP_W = WORD_W - RSVD_TOP;

    logic [WORD_W-1:0] keep;

    // Pick the writable field according to the reserved width.
    generate
        if (RSVD_TOP > 0) begin : g_rsvd
            assign keep = {{RSVD_TOP{1'b0}}, {KEEP_W{1'b1}}};
        end else begin : g_full
            assign keep = '1;
        end
    endgenerate

    // Store the writable part of the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= '0;
        else if (wr_i) mask_o <= wdata_i & keep;
    end
endmodule

// File: rtl/evt_irq_combine.sv
// Merges live levels and held events into raw status, applies the mask
// and reduces the masked word to one interrupt line. Combinational.
module evt_irq_combine #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] lvl_i,
    input  logic [WORD_W-1:0] held_i,
    input  logic [WORD_W-1:0] mask_i,
    output logic [WORD_W-1:0] raw_o,
    output logic [WORD_W-1:0] masked_o,
    output logic              irq_o
);
    // Form raw and masked words and the interrupt line.
    always_comb begin
        raw_o    = lvl_i | held_i;
        masked_o = raw_o & mask_i;
        irq_o    = |masked_o;
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
// Top of the interrupt status unit: maps inputs, holds events, stores the
// mask and drives the interrupt line. Assumes pulses last one cycle or are
// treated as repeated sets while high.
module evt_irq_ctrl #(
    parameter int WORD_W   = 32,
    parameter int RSVD_TOP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_empty_i,
    input  logic              tx_low_i,
    input  logic              tx_full_i,
    input  logic              rx_empty_i,
    input  logic              rx_high_i,
    input  logic              rx_full_i,
    input  logic              tx_ovr_i,
    input  logic              sl_rd_req_i,
    input  logic              sl_rd_empty_i,
    input  logic              sl_wr_req_i,
    input  logic              mst_done_i,
    input  logic              slv_done_i,
    input  logic              arb_lost_i,
    input  logic              bus_err_i,
    input  logic              mst_done_ns_i,
    input  logic              mask_wr_i,
    input  logic              clr_wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] raw_stat_o,
    output logic [WORD_W-1:0] mask_stat_o,
    output logic              irq_o
);
    import evt_irq_pkg::*;

    localparam logic [WORD_W-1:0] HELD_W = WORD_W'(HELD_MAP);
    localparam logic [WORD_W-1:0] CLR_W  = WORD_W'(CLEARABLE_MAP);

    logic [WORD_W-1:0] lvl_vec;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] held_vec;

    evt_map #(.WORD_W(WORD_W)) u_map (
        .tx_empty_i    (tx_empty_i),
        .tx_low_i      (tx_low_i),
        .tx_full_i     (tx_full_i),
        .rx_empty_i    (rx_empty_i),
        .rx_high_i     (rx_high_i),
        .rx_full_i     (rx_full_i),
        .tx_ovr_i      (tx_ovr_i),
        .sl_rd_req_i   (sl_rd_req_i),
        .sl_rd_empty_i (sl_rd_empty_i),
        .sl_wr_req_i   (sl_wr_req_i),
        .mst_done_i    (mst_done_i),
        .slv_done_i    (slv_done_i),
        .arb_lost_i    (arb_lost_i),
        .bus_err_i     (bus_err_i),
        .mst_done_ns_i (mst_done_ns_i),
        .lvl_vec_o     (lvl_vec),
        .set_vec_o     (set_vec)
    );

    evt_held_bank #(.WORD_W(WORD_W), .HELD(HELD_W), .CLR_MAP(CLR_W)) u_held (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_stb_i  (clr_wr_i),
        .clr_data_i (wdata_i),
        .held_o     (held_vec)
    );

    evt_mask_reg #(.WORD_W(WORD_W), .RSVD_TOP(RSVD_TOP)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr_i),
        .wdata_i (wdata_i),
        .mask_o  (mask_o)
    );

    evt_irq_combine #(.WORD_W(WORD_W)) u_comb (
        .lvl_i    (lvl_vec),
        .held_i   (held_vec),
        .mask_i   (mask_o),
        .raw_o    (raw_stat_o),
        .masked_o (mask_stat_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
// Property checker for evt_irq_ctrl, attached by bind. Assumes the default
// 32-bit word with three reserved top bits.
module evt_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_empty_i,
    input logic        rx_full_i,
    input logic        mst_done_i,
    input logic        arb_lost_i,
    input logic        bus_err_i,
    input logic        mask_wr_i,
    input logic        clr_wr_i,
    input logic [31:0] wdata_i,
    input logic [31:0] mask_o,
    input logic [31:0] raw_stat_o,
    input logic [31:0] mask_stat_o,
    input logic        irq_o
);
    a_r1_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        raw_stat_o[0] == tx_empty_i && raw_stat_o[6] == rx_full_i);

    a_r2_event_latch: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_i |=> raw_stat_o[24]);

    a_r2_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
        raw_stat_o[25] && !(clr_wr_i && wdata_i[25]) |=> raw_stat_o[25]);

    a_r3_clear_drop: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i && wdata_i[19] && !mst_done_i |=> !raw_stat_o[19]);

    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_i && clr_wr_i && wdata_i[25] |=> raw_stat_o[25]);

    a_r5_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        raw_stat_o[31:29] == 3'b000 && mask_o[31:29] == 3'b000);

    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> mask_o[28:0] == $past(wdata_i[28:0]));

    a_r6_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_stat_o & ~mask_o) == 32'h0 && (mask_stat_o & ~raw_stat_o) == 32'h0);

    a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o == 32'h0 |-> !irq_o);

    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw_stat_o != 32'h0 && mask_o != 32'h0));

    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> mask_o == 32'h0 && (raw_stat_o & 32'h131f_0008) == 32'h0);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_empty_i  (tx_empty_i),
    .rx_full_i   (rx_full_i),
    .mst_done_i  (mst_done_i),
    .arb_lost_i  (arb_lost_i),
    .bus_err_i   (bus_err_i),
    .mask_wr_i   (mask_wr_i),
    .clr_wr_i    (clr_wr_i),
    .wdata_i     (wdata_i),
    .mask_o      (mask_o),
    .raw_stat_o  (raw_stat_o),
    .mask_stat_o (mask_stat_o),
    .irq_o       (irq_o)
);

// File: tb/sim_evt_irq_ctrl.sv
// Bench for evt_irq_ctrl: a table walk against a requirement-level model,
// then directed tests for every event, reserved clears and reset.
module sim_evt_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  lvl = '0;
    logic [8:0]  pls = '0;
    logic        mask_wr = 1'b0;
    logic        clr_wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] mask_o, raw_o, mstat_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_empty_i(lvl[0]), .tx_low_i(lvl[1]), .tx_full_i(lvl[2]),
        .rx_empty_i(lvl[3]), .rx_high_i(lvl[4]), .rx_full_i(lvl[5]),
        .tx_ovr_i(pls[0]), .sl_rd_req_i(pls[1]), .sl_rd_empty_i(pls[2]),
        .sl_wr_req_i(pls[3]), .mst_done_i(pls[4]), .slv_done_i(pls[5]),
        .arb_lost_i(pls[6]), .bus_err_i(pls[7]), .mst_done_ns_i(pls[8]),
        .mask_wr_i(mask_wr), .clr_wr_i(clr_wr), .wdata_i(wdata),
        .mask_o(mask_o), .raw_stat_o(raw_o), .mask_stat_o(mstat_o), .irq_o(irq_o)
    );

    // Row: {levels[5:0], pulses[8:0], mask_wr, clr_wr, wdata[31:0], irq}
    localparam logic [49:0] TBL [ROWS] = '{
        {6'h01, 9'h000, 1'b0, 1'b0, 32'h0000_0000, 1'b0},
        {6'h01, 9'h000, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R5 top field
        {6'h00, 9'h040, 1'b0, 1'b0, 32'h0000_0000, 1'b1}, // R2
        {6'h00, 9'h000, 1'b0, 1'b1, 32'h0100_0000, 1'b0}, // R3
        {6'h00, 9'h180, 1'b1, 1'b0, 32'h1000_0000, 1'b1},
        {6'h00, 9'h000, 1'b0, 1'b1, 32'h1000_0000, 1'b0},
        {6'h00, 9'h000, 1'b0, 1'b1, 32'hEC00_FF80, 1'b0}, // R3 reserved
        {6'h00, 9'h001, 1'b1, 1'b0, 32'h0200_0000, 1'b1},
        {6'h00, 9'h080, 1'b0, 1'b1, 32'h0200_0008, 1'b1}, // R4
        {6'h00, 9'h000, 1'b0, 1'b1, 32'h0200_0000, 1'b0},
        {6'h3F, 9'h000, 1'b0, 1'b1, 32'h0000_0077, 1'b0}, // R1 R3 level
        {6'h3F, 9'h000, 1'b1, 1'b0, 32'h0000_0040, 1'b1},
        {6'h3F, 9'h000, 1'b1, 1'b0, 32'h0000_0000, 1'b0}  // R7 zero mask
    };

    logic [31:0] m_held = '0;
    logic [31:0] m_mask = '0;

    function automatic int pulse_pos(input int k);
        case (k)
            0: return 3;   1: return 16;  2: return 17;
            3: return 18;  4: return 19;  5: return 20;
            6: return 24;  7: return 25;  default: return 28;
        endcase
    endfunction

    function automatic int level_pos(input int k);
        return (k < 3) ? k : k + 1;
    endfunction

    function automatic logic [31:0] lvl_word(input logic [5:0] l);
        logic [31:0] w = '0;
        for (int k = 0; k < 6; k++) w[level_pos(k)] = l[k];
        return w;
    endfunction

    function automatic logic [31:0] pls_word(input logic [8:0] p);
        logic [31:0] w = '0;
        for (int k = 0; k < 9; k++) w[pulse_pos(k)] = p[k];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] exp_raw;
        repeat (2) @(negedge clk);
        // R8 reset state
        chk("R8 mask after reset", mask_o, 32'h0);
        chk("R8 raw after reset", raw_o, 32'h0);
        chk("R8 irq after reset", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;

        for (int r = 0; r < ROWS; r++) begin
            lvl     = TBL[r][49:44];
            pls     = TBL[r][43:35];
            mask_wr = TBL[r][34];
            clr_wr  = TBL[r][33];
            wdata   = TBL[r][32:1];
            @(negedge clk);
            m_held = (m_held & ~(clr_wr ? (wdata & 32'h131f_007f) : 32'h0)
                      & 32'h131f_0008) | pls_word(pls);
            if (mask_wr) m_mask = wdata & 32'h1FFF_FFFF;
            exp_raw = m_held | lvl_word(lvl);
            chk("R1 R2 R3 R4 raw status", raw_o, exp_raw);
            chk("R5 mask readback", mask_o, m_mask);
            chk("R6 masked status", mstat_o, exp_raw & m_mask);
            chk("R7 irq line", {31'h0, irq_o}, {31'h0, TBL[r][0]});
            pls = '0; mask_wr = 1'b0; clr_wr = 1'b0;
        end

        // R2 each event alone, then R3 full clear
        lvl = '0; mask_wr = 1'b1; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        mask_wr = 1'b0;
        for (int k = 0; k < 9; k++) begin
            pls = 9'h001 << k;
            @(negedge clk);
            pls = '0;
            @(negedge clk);
            chk("R2 single event held", raw_o, 32'h1 << pulse_pos(k));
            clr_wr = 1'b1; wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            clr_wr = 1'b0;
            chk("R3 clear all", raw_o, 32'h0);
        end

        // R1 each level alone, live and not held
        for (int k = 0; k < 6; k++) begin
            lvl = 6'h01 << k;
            #1;
            chk("R1 level live", raw_o, 32'h1 << level_pos(k));
            @(negedge clk);
        end
        lvl = '0;
        @(negedge clk);
        chk("R1 level not held", raw_o, 32'h0);

        // R8 reset with events and mask loaded
        pls = 9'h1FF;
        @(negedge clk);
        pls = '0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mask cleared", mask_o, 32'h0);
        chk("R8 held cleared", raw_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule